// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is one slice of a processor datapath. It holds seven general-purpose registers and one shared arithmetic, logic and shift unit. Each clock cycle a single packed control word names the register that feeds operand bus A, the register that feeds operand bus B, the operation to perform and the register that receives the answer. A source code of zero puts the external data input on that bus, so operands from outside the register set need no extra path.

The result of the operation is driven combinationally on the `result` port during the same cycle. It is written into the chosen destination register at the next rising clock edge. A destination code of zero leaves every register untouched while the result is still visible on the port. All register contents are brought out for observation. Sequencing, microcode storage and instruction decode are left to the surrounding logic, which must hold the control word stable for the whole cycle.

Top module: `rdp_datapath`

## Requirements
- R1: The 14-bit control word is split, most significant bits first, into bus-A source `[13:11]`, bus-B source `[10:8]`, destination `[7:5]` and operation code `[4:0]`.
- R2: On each bus, source code 0 selects `data_in`, and source code k (1 to 7) selects register k.
- R3: A non-zero destination code k loads register k with the `result` value of that cycle at the next rising clock edge.
- R4: Only the register named by the destination code changes at an edge. All other registers keep their value.
- R5: Destination code 0 loads no register, but the operation's result still appears on `result`.
- R6: `result` depends combinationally on the current control word, `data_in` and the register contents, and is valid within the same cycle.
- R7: The arithmetic codes operate modulo 2^WIDTH in two's complement: 00000 gives A, 00001 gives A+1, 00010 gives A+B, 00101 gives A-B and 00110 gives A-1.
- R8: The logic codes are bitwise: 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B and 01110 gives NOT A.
- R9: Code 10000 shifts A right by one and code 11000 shifts A left by one. Both are logical shifts that fill the vacated bit with zero.
- R10: Any operation code not listed in R7 to R9 passes A through unchanged.
- R11: A synchronous active-high `rst` clears every register to zero at the next edge and takes priority over a load in the same cycle.
- R12: A register may be a source and the destination in one cycle. The operands then use its value before the edge, and it takes the new result after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 14 | Packed control word: A source, B source, destination, operation |
| data_in | input | WIDTH | External operand, selected by source code 0 |
| result | output | WIDTH | Combinational ALU result for the current control word |
| reg_view | output | 7*WIDTH | Register contents, register k at bits `[(k-1)*WIDTH +: WIDTH]` |

## Verification
The datapath reads operands and writes the destination in the same cycle, so these two functions can collide on one register. The bench provokes the collision with words such as R1 <- R1 + R1 and R7 <- R7 + 1 on a value of 0xFF. It judges the result port against the pre-edge operands and checks the register one cycle later against that result. A reset cycle that also carries a load is used to show that clearing wins over writing.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
    localparam int SEL_W = 3;
    localparam int OP_W  = 5;
    localparam int NREG  = (1 << SEL_W) - 1;
    localparam int CW_W  = 3 * SEL_W + OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_TFR = 5'b00000,
        OP_INC = 5'b00001,
        OP_ADD = 5'b00010,
        OP_SUB = 5'b00101,
        OP_DEC = 5'b00110,
        OP_AND = 5'b01000,
        OP_OR  = 5'b01010,
        OP_XOR = 5'b01100,
        OP_NOT = 5'b01110,
        OP_SHR = 5'b10000,
        OP_SHL = 5'b11000
    } alu_op_e;

    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [SEL_W-1:0] dst;
        logic [OP_W-1:0]  op;
    } ctl_word_t;
endpackage

// File: rtl/rdp_ctl_decode.sv
module rdp_ctl_decode
    import rdp_pkg::*;
(
    input  logic [CW_W-1:0] cw,
    output ctl_word_t       fields,
    output logic [NREG-1:0] load_en
);
    assign fields = ctl_word_t'(cw);

    // one load line per register; code 0 matches none of them
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign load_en[g] = (fields.dst == SEL_W'(g + 1));
    end
endmodule

// File: rtl/rdp_alu.sv
module rdp_alu
    import rdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [OP_W-1:0]  op,
    output logic [WIDTH-1:0] y
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        case (op)
            OP_TFR:  y = a;
            OP_INC:  y = a + ONE;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a + ~b + ONE;
            OP_DEC:  y = a - ONE;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            OP_SHR:  y = {1'b0, a[WIDTH-1:1]};
            OP_SHL:  y = {a[WIDTH-2:0], 1'b0};
            default: y = a;
        endcase
    end
endmodule

// File: rtl/rdp_regs.sv
module rdp_regs
    import rdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NREG-1:0]       load_en,
    input  logic [WIDTH-1:0]      wr_data,
    input  logic [SEL_W-1:0]      sel_a,
    input  logic [SEL_W-1:0]      sel_b,
    input  logic [WIDTH-1:0]      ext_in,
    output logic [WIDTH-1:0]      bus_a,
    output logic [WIDTH-1:0]      bus_b,
    output logic [NREG*WIDTH-1:0] regs_flat
);
    typedef struct packed {
        logic [NREG-1:0][WIDTH-1:0] r;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (load_en[i]) st_d.r[i] = wr_data;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // operand selection: code 0 keeps the external input
    always_comb begin
        bus_a = ext_in;
        bus_b = ext_in;
        for (int i = 0; i < NREG; i++) begin
            if (sel_a == SEL_W'(i + 1)) bus_a = st_q.r[i];
            if (sel_b == SEL_W'(i + 1)) bus_b = st_q.r[i];
        end
    end

    assign regs_flat = st_q;
endmodule

// File: rtl/rdp_datapath.sv
module rdp_datapath
    import rdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CW_W-1:0]       ctrl_word,
    input  logic [WIDTH-1:0]      data_in,
    output logic [WIDTH-1:0]      result,
    output logic [NREG*WIDTH-1:0] reg_view
);
    ctl_word_t        fld;
    logic [NREG-1:0]  ld;
    logic [WIDTH-1:0] opa, opb;

    rdp_ctl_decode u_dec (
        .cw      (ctrl_word),
        .fields  (fld),
        .load_en (ld)
    );

    rdp_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .load_en   (ld),
        .wr_data   (result),
        .sel_a     (fld.src_a),
        .sel_b     (fld.src_b),
        .ext_in    (data_in),
        .bus_a     (opa),
        .bus_b     (opb),
        .regs_flat (reg_view)
    );

    rdp_alu #(.WIDTH(WIDTH)) u_alu (
        .a  (opa),
        .b  (opb),
        .op (fld.op),
        .y  (result)
    );
endmodule

// File: rtl/rdp_datapath_chk.sv
module rdp_datapath_chk
    import rdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [CW_W-1:0]       ctrl_word,
    input logic [WIDTH-1:0]      data_in,
    input logic [WIDTH-1:0]      result,
    input logic [NREG*WIDTH-1:0] reg_view
);
    logic [SEL_W-1:0] c_a, c_b, c_d;
    logic [OP_W-1:0]  c_op;
    assign c_a  = ctrl_word[CW_W-1 -: SEL_W];
    assign c_b  = ctrl_word[CW_W-1-SEL_W -: SEL_W];
    assign c_d  = ctrl_word[OP_W +: SEL_W];
    assign c_op = ctrl_word[OP_W-1:0];

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (reg_view == '0));

    // R2
    ext_src_chk: assert property (@(posedge clk) disable iff (rst)
        (c_a == '0 && c_op == OP_TFR) |-> (result == data_in));

    // R7
    add_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (c_a == '0 && c_b == '0 && c_op == OP_ADD)
        |-> (result == {data_in[WIDTH-2:0], 1'b0}));

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // R3
        load_lands_chk: assert property (@(posedge clk) disable iff (rst)
            (c_d == SEL_W'(g + 1)) |=> (reg_view[g*WIDTH +: WIDTH] == $past(result)));

        // R4
        others_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (c_d != SEL_W'(g + 1)) |=> $stable(reg_view[g*WIDTH +: WIDTH]));

        // R12
        self_inc_chk: assert property (@(posedge clk) disable iff (rst)
            (c_d == SEL_W'(g + 1) && c_a == SEL_W'(g + 1) && c_op == OP_INC)
            |=> (reg_view[g*WIDTH +: WIDTH]
                 == WIDTH'($past(reg_view[g*WIDTH +: WIDTH]) + 1)));
    end
endmodule

bind rdp_datapath rdp_datapath_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_word (ctrl_word),
    .data_in   (data_in),
    .result    (result),
    .reg_view  (reg_view)
);

// File: tb/tb_rdp_datapath.sv
module tb_rdp_datapath;
    localparam int W = 8;
    localparam int N = 7;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [13:0]    ctrl_word = '0;
    logic [W-1:0]   data_in = '0;
    logic [W-1:0]   result;
    logic [N*W-1:0] reg_view;

    int total = 0;
    int bad   = 0;

    logic [W-1:0]   mreg [1:N];
    logic [W-1:0]   q_res  [$];
    logic [N*W-1:0] q_regs [$];
    string          q_tag  [$];

    always #10 clk = ~clk;

    rdp_datapath #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
        .data_in(data_in), .result(result), .reg_view(reg_view)
    );

    function automatic logic [W-1:0] model_alu(logic [4:0] op, logic [W-1:0] a, logic [W-1:0] b);
        case (op)
            5'b00001: return a + 1'b1;
            5'b00010: return a + b;
            5'b00101: return a - b;
            5'b00110: return a - 1'b1;
            5'b01000: return a & b;
            5'b01010: return a | b;
            5'b01100: return a ^ b;
            5'b01110: return ~a;
            5'b10000: return a >> 1;
            5'b11000: return a << 1;
            default:  return a;
        endcase
    endfunction

    function automatic logic [N*W-1:0] snap();
        logic [N*W-1:0] s;
        for (int k = 1; k <= N; k++) s[(k-1)*W +: W] = mreg[k];
        return s;
    endfunction

    task automatic check(bit ok, string tag, logic [N*W-1:0] act, logic [N*W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(logic [2:0] sa, logic [2:0] sb, logic [2:0] sd,
                          logic [4:0] op, logic [W-1:0] din, string tag);
        logic [W-1:0] a, b, r;
        @(negedge clk);
        ctrl_word = {sa, sb, sd, op};
        data_in   = din;
        a = (sa == 0) ? din : mreg[sa];
        b = (sb == 0) ? din : mreg[sb];
        r = model_alu(op, a, b);
        q_res.push_back(r);
        q_regs.push_back(snap());
        q_tag.push_back(tag);
        if (sd != 0) mreg[sd] = r;
    endtask

    // monitor: compares result within the cycle and the register state the
    // previous operations should have left
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q_res.size() > 0) begin
                logic [W-1:0]   er;
                logic [N*W-1:0] eg;
                string          t;
                er = q_res.pop_front();
                eg = q_regs.pop_front();
                t  = q_tag.pop_front();
                check(result == er, {t, " result"}, {{(N-1)*W{1'b0}}, result}, {{(N-1)*W{1'b0}}, er});
                check(reg_view == eg, {t, " regs"}, reg_view, eg);
            end
        end
    end

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 1; k <= N; k++) mreg[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        // R11 reset state
        check(reg_view == '0, "R11 reset state", reg_view, '0);

        // R2 R3 load every register from the external input
        for (int k = 1; k <= N; k++)
            run_op(3'd0, 3'd0, 3'(k), 5'b00000, 8'(8'h11 * k), "R2 R3 load");
        run_op(3'd2, 3'd3, 3'd1, 5'b00010, 8'h00, "R1 R7 add R2+R3");
        run_op(3'd3, 3'd0, 3'd0, 5'b00010, 8'h05, "R1 R2 B external");
        run_op(3'd5, 3'd6, 3'd4, 5'b00101, 8'h00, "R7 sub wrap");
        run_op(3'd0, 3'd0, 3'd7, 5'b00000, 8'hFF, "R3 load FF");
        run_op(3'd7, 3'd0, 3'd7, 5'b00001, 8'h00, "R12 R7 inc wrap self");
        run_op(3'd7, 3'd0, 3'd6, 5'b00110, 8'h00, "R7 dec wrap");
        run_op(3'd0, 3'd0, 3'd5, 5'b00010, 8'h81, "R7 add external twice");
        run_op(3'd0, 3'd2, 3'd1, 5'b01000, 8'hF0, "R8 and");
        run_op(3'd0, 3'd2, 3'd2, 5'b01010, 8'h0F, "R8 or");
        run_op(3'd4, 3'd5, 3'd3, 5'b01100, 8'h00, "R8 xor");
        run_op(3'd3, 3'd0, 3'd4, 5'b01110, 8'h00, "R8 not");
        run_op(3'd0, 3'd0, 3'd1, 5'b10000, 8'h81, "R9 shr zero fill");
        run_op(3'd0, 3'd0, 3'd2, 5'b11000, 8'h81, "R9 shl zero fill");
        run_op(3'd4, 3'd1, 3'd3, 5'b00011, 8'h00, "R10 unlisted 00011");
        run_op(3'd2, 3'd1, 3'd5, 5'b11111, 8'h00, "R10 unlisted 11111");
        run_op(3'd2, 3'd3, 3'd0, 5'b00010, 8'h00, "R5 R6 no destination");
        run_op(3'd0, 3'd0, 3'd0, 5'b01110, 8'h3C, "R5 no destination ext");
        run_op(3'd1, 3'd1, 3'd1, 5'b00010, 8'h00, "R12 R1=R1+R1");
        run_op(3'd6, 3'd6, 3'd6, 5'b00101, 8'h00, "R12 R6=R6-R6");
        run_op(3'd0, 3'd0, 3'd0, 5'b00000, 8'h00, "R4 flush");

        // R11 reset wins over a load in the same cycle
        @(negedge clk);
        rst = 1'b1;
        ctrl_word = {3'd0, 3'd0, 3'd1, 5'b00000};
        data_in = 8'hAA;
        @(negedge clk);
        rst = 1'b0;
        ctrl_word = '0;
        #5;
        check(reg_view == '0, "R11 reset over load", reg_view, '0);
        for (int k = 1; k <= N; k++) mreg[k] = '0;
        run_op(3'd1, 3'd0, 3'd0, 5'b00001, 8'h00, "R11 after reset");
        run_op(3'd0, 3'd0, 3'd0, 5'b00000, 8'h00, "R4 final flush");

        repeat (2) @(negedge clk);
        #6;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule